// File: doc/BRIEF.md
# UART Receive Idle Timeout Timer

This block raises an interrupt request when a FIFO-mode UART receiver has data waiting that nobody has collected, and the serial line has gone quiet. It counts bit periods, marked by a one-cycle bit tick from the baud generator, since the last restart. A restart is any character written into the receive FIFO or any read from it. The request asserts once four whole character times have passed with data still held in the FIFO. A character time is one start bit, the data bits, one parity bit and one stop bit, so the threshold depends on the selected word length.

The surrounding UART supplies the FIFO's not-empty flag and one-cycle strobes for each character pushed and each character popped. It also supplies an interrupt enable and the module reset bit, which is active low. The output is a plain level request for the interrupt prioritizer. Every input is a control strobe or level, so no valid/ready handshake is involved. A strobe counts in the cycle it is high and the block never applies back-pressure.

Top module: `uart_rx_idle_timeout`

## Requirements
- R1: `timeout_irq` is low in every cycle that follows a clock edge at which `fifo_nonempty` was low. While the FIFO is empty the timer is held at zero, so after a refill a full threshold must elapse again.
- R2: `word_len` selects the threshold: code 00 gives 32, 01 gives 36, 10 gives 40 and 11 gives 44 counted bit ticks. `timeout_irq` rises on the clock edge that counts the threshold-th `bit_tick` since the last restart, and at no earlier edge.
- R3: Before a timeout, a `char_push` restarts the count from zero. A `char_push` in the same cycle as a `bit_tick` wins, and that tick is not counted.
- R4: Before a timeout, a `fifo_pop` restarts the count from zero.
- R5: Once `timeout_irq` is high it stays high until a clearing event occurs. Further bit ticks and changes of `word_len` do not lower it.
- R6: A `fifo_pop` while `timeout_irq` is high drops it on the next edge and restarts the timer. A new full threshold is then needed to assert it again.
- R7: A `char_push` while `timeout_irq` is high drops it on the next edge and restarts the timer.
- R8: While `mod_rst_n` is low, the request is cleared and the timer is held at zero.
- R9: While `enable` is low, the request is cleared and the timer is held at zero.
- R10: Only cycles with `bit_tick` high advance the timer. Idle cycles between ticks have no effect on when the request rises.
- R11: After `rst_n` is released, `timeout_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| word_len | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| fifo_nonempty | input | 1 | Receive FIFO holds at least one character |
| char_push | input | 1 | A received character entered the FIFO this cycle |
| fifo_pop | input | 1 | A character was read from the FIFO this cycle |
| enable | input | 1 | Timeout interrupt enabled |
| mod_rst_n | input | 1 | Module reset bit of the UART, active low |
| timeout_irq | output | 1 | Receive idle timeout request |

## Verification
The bench runs each of the four word lengths to its exact threshold, with a tick on every cycle and with idle cycles between ticks. A design off by one tick, or one that ignored the word length, would assert one edge early or late. It restarts the count one tick short of the threshold, by a push and by a pop. It also pairs a push with a tick in the same cycle, where a design that let the tick through would time out one tick early. Once the request is high, the bench checks that it survives extra ticks and a smaller word length. It then checks that a pop, a push, a drained FIFO, the module reset bit and the enable each drop it, and that each forces a full recount. A design that only masked the output without clearing the count would fire again too soon.

// File: rtl/uart_rxto_pkg.sv
package uart_rxto_pkg;
  // Word-length field width and characters per timeout window
  localparam int WL_W        = 2;
  localparam int NUM_CODES   = 1 << WL_W;
  localparam int CHAR_WINDOW = 4;
  // Smallest data width and framing bits (start + parity + stop)
  localparam int MIN_DATA    = 5;
  localparam int FRAME_OVH   = 3;
  localparam int MAX_LIMIT   = CHAR_WINDOW * (FRAME_OVH + MIN_DATA + NUM_CODES - 1);
  localparam int CNT_W       = $clog2(MAX_LIMIT + 1);

  // Bit periods in the timeout window for a given word-length code
  function automatic int window_bits(input int code);
    return CHAR_WINDOW * (FRAME_OVH + MIN_DATA + code);
  endfunction
endpackage

// File: rtl/uart_rxto_limit.sv
module uart_rxto_limit
  import uart_rxto_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int LW = WL_W
) (
  input  logic [LW-1:0] word_len,
  output logic [CW-1:0] limit
);
  localparam int CODES = 1 << LW;

  logic [CW-1:0] table_q [CODES];

  for (genvar g = 0; g < CODES; g++) begin : g_code
    localparam int BITS = window_bits(g);
    assign table_q[g] = CW'(BITS);
  end

  assign limit = table_q[word_len];
endmodule

// File: rtl/uart_rxto_restart.sv
module uart_rxto_restart (
  input  logic bit_tick,
  input  logic fifo_nonempty,
  input  logic char_push,
  input  logic fifo_pop,
  input  logic enable,
  input  logic mod_rst_n,
  output logic restart,
  output logic advance
);
  logic inactive;

  // Conditions that hold the timer at zero rather than restart it once
  assign inactive = !fifo_nonempty || !enable || !mod_rst_n;
  // Any FIFO traffic, or the timer being parked, forces a fresh count
  assign restart  = inactive || char_push || fifo_pop;
  // A tick counts only when nothing restarts in the same cycle
  assign advance  = bit_tick && !restart;
endmodule

// File: rtl/uart_rxto_count.sv
module uart_rxto_count
  import uart_rxto_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          advance,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic          below;
  logic          reach;

  assign below = cnt_q < limit;
  // The counted tick is the one that brings the count up to the limit
  assign reach = advance && ({1'b0, cnt_q} + 1'b1 >= {1'b0, limit});

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (restart) begin
      cnt_d  = '0;
      flag_d = 1'b0;
    end else begin
      if (advance && below) cnt_d = cnt_q + 1'b1;
      if (reach) flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign expired = flag_q;
endmodule

// File: rtl/uart_rx_idle_timeout.sv
module uart_rx_idle_timeout
  import uart_rxto_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_tick,
  input  logic [WL_W-1:0] word_len,
  input  logic            fifo_nonempty,
  input  logic            char_push,
  input  logic            fifo_pop,
  input  logic            enable,
  input  logic            mod_rst_n,
  output logic            timeout_irq
);
  logic [CNT_W-1:0] limit;
  logic             restart;
  logic             advance;

  uart_rxto_limit #(.CW(CNT_W), .LW(WL_W)) u_limit (
    .word_len (word_len),
    .limit    (limit)
  );

  uart_rxto_restart u_restart (
    .bit_tick      (bit_tick),
    .fifo_nonempty (fifo_nonempty),
    .char_push     (char_push),
    .fifo_pop      (fifo_pop),
    .enable        (enable),
    .mod_rst_n     (mod_rst_n),
    .restart       (restart),
    .advance       (advance)
  );

  uart_rxto_count #(.CW(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .advance (advance),
    .limit   (limit),
    .expired (timeout_irq)
  );
endmodule

// File: rtl/uart_rxto_chk.sv
module uart_rxto_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic fifo_nonempty,
  input logic char_push,
  input logic fifo_pop,
  input logic enable,
  input logic mod_rst_n,
  input logic timeout_irq
);
  AST_EMPTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_nonempty |=> !timeout_irq); // R1

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_irq) |-> $past(bit_tick)); // R2

  AST_HOLD_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_irq && fifo_nonempty && enable && mod_rst_n && !char_push && !fifo_pop)
      |=> timeout_irq); // R5

  AST_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !timeout_irq); // R6

  AST_PUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    char_push |=> !timeout_irq); // R7

  AST_MODRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_rst_n |=> !timeout_irq); // R8

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !timeout_irq); // R9
endmodule

bind uart_rx_idle_timeout uart_rxto_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bit_tick      (bit_tick),
  .fifo_nonempty (fifo_nonempty),
  .char_push     (char_push),
  .fifo_pop      (fifo_pop),
  .enable        (enable),
  .mod_rst_n     (mod_rst_n),
  .timeout_irq   (timeout_irq)
);

// File: tb/uart_rx_idle_timeout_bench.sv
`timescale 1ns/100ps
module uart_rx_idle_timeout_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_tick, fifo_nonempty, char_push, fifo_pop, enable, mod_rst_n;
  logic [1:0] word_len;
  logic       timeout_irq;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  bit  q_exp[$];
  string q_tag[$];
  // Bench-side state applied together with each cycle's strobes
  bit  s_ne = 0, s_en = 1, s_mr = 1;
  int  s_wl = 3;

  always #2.5 clk = ~clk;

  uart_rx_idle_timeout u_uart_rx_idle_timeout (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .word_len(word_len),
    .fifo_nonempty(fifo_nonempty), .char_push(char_push), .fifo_pop(fifo_pop),
    .enable(enable), .mod_rst_n(mod_rst_n), .timeout_irq(timeout_irq)
  );

  function automatic int thr(int w);
    return 32 + 4 * w;
  endfunction

  // Driver: apply one cycle of stimulus and queue the expected request level
  task automatic cyc(bit tk, bit ps, bit pp, bit e, string tag);
    @(negedge clk);
    bit_tick      = tk;
    char_push     = ps;
    fifo_pop      = pp;
    fifo_nonempty = s_ne;
    enable        = s_en;
    mod_rst_n     = s_mr;
    word_len      = 2'(s_wl);
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  // n ticks, each followed by gap idle cycles; high from tick number l on
  task automatic run(int n, int gap, int l, bit pre, string tag);
    for (int i = 1; i <= n; i++) begin
      cyc(1'b1, 1'b0, 1'b0, pre || i >= l, tag);
      for (int j = 0; j < gap; j++) cyc(1'b0, 1'b0, 1'b0, pre || i >= l, tag);
    end
  endtask

  // Monitor: compare each queued expectation just after its clock edge
  initial begin
    forever begin
      bit    e;
      string t;
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) begin
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        checks++;
        if (timeout_irq !== e) begin
          errors++;
          $display("FAIL %s: timeout_irq=%0b expected %0b at %0t", t, timeout_irq, e, $time);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bit_tick = 0; char_push = 0; fifo_pop = 0;
    fifo_nonempty = 0; enable = 1; mod_rst_n = 1; word_len = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc(0, 0, 0, 0, "R11 reset state");

    // R1: empty FIFO, many ticks, never a request
    s_ne = 0;
    run(60, 0, 1000, 0, "R1 empty fifo");
    s_ne = 1;

    // R2 exact thresholds per word length, R6 pop clears
    for (int w = 0; w < 4; w++) begin
      s_wl = w;
      cyc(0, 1, 0, 0, "R2 push start");
      run(thr(w), 1, thr(w), 0, "R2 threshold");
      cyc(0, 0, 1, 0, "R6 pop clears");
    end

    // R10 sparse ticks, then R5 saturation and word-length change
    s_wl = 2;
    cyc(0, 1, 0, 0, "R10 push start");
    run(thr(2), 3, thr(2), 0, "R10 sparse ticks");
    run(10, 0, 1, 1, "R5 extra ticks");
    s_wl = 0;
    cyc(0, 0, 0, 1, "R5 word_len change");
    run(3, 0, 1, 1, "R5 after change");
    s_wl = 2;

    // R6 pop clears then full recount
    cyc(0, 0, 1, 0, "R6 pop clears");
    run(thr(2), 0, thr(2), 0, "R6 recount");

    // R7 push clears then full recount
    cyc(0, 1, 0, 0, "R7 push clears");
    run(thr(2), 0, thr(2), 0, "R7 recount");

    // R1 drained FIFO clears and parks the timer
    s_ne = 0;
    cyc(0, 0, 0, 0, "R1 drained");
    s_ne = 1;
    run(thr(2), 0, thr(2), 0, "R1 refill recount");

    // R8 module reset bit
    s_mr = 0;
    cyc(0, 0, 0, 0, "R8 clears");
    run(50, 0, 1000, 0, "R8 held");
    s_mr = 1;
    run(thr(2), 0, thr(2), 0, "R8 recount");

    // R9 enable
    s_en = 0;
    cyc(0, 0, 0, 0, "R9 clears");
    run(50, 0, 1000, 0, "R9 held");
    s_en = 1;
    run(thr(2), 0, thr(2), 0, "R9 recount");

    // R3 push one tick short restarts; push beats same-cycle tick
    s_wl = 1;
    cyc(0, 1, 0, 0, "R3 push start");
    run(thr(1) - 1, 0, 1000, 0, "R3 short");
    cyc(0, 1, 0, 0, "R3 push restarts");
    run(thr(1), 0, thr(1), 0, "R3 recount");
    cyc(1, 1, 0, 0, "R3 push beats tick");
    run(thr(1), 0, thr(1), 0, "R3 tick not counted");

    // R4 pop one tick short restarts
    s_wl = 3;
    cyc(0, 0, 1, 0, "R4 pop start");
    run(thr(3) - 1, 0, 1000, 0, "R4 short");
    cyc(0, 0, 1, 0, "R4 pop restarts");
    run(thr(3), 0, thr(3), 0, "R4 recount");

    cyc(0, 0, 0, 1, "R5 idle hold");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule